// File: doc/BRIEF.md
# Invalidation Completion Event Controller

This block turns completion notices from an invalidation queue engine into a message-style interrupt request. It keeps a sticky "wait complete" flag, a mask bit and a pending bit, together with three plain storage words that give the interrupt message its data and its 64-bit target address. Software reaches all of this through a simple write strobe and select. It reads the same state back through a select and a read-data bus. The read path is combinational.

A completion pulse has an effect only when the completion flag is clear. It sets the flag and raises an event. If the event is unmasked and the output is free, a message with the currently stored address and data is launched. Otherwise the event stays pending. It is delivered once software unmasks it and the output can take it. Messages leave through a valid/ready pair and are held stable until accepted.

Top module: `inv_cpl_evt_ctrl`

## Requirements
- R1: After reset the completion flag (status word bit 0) is 0, the control word reads 0x8000_0000 (mask bit 31 set, pending bit 30 clear), the storage words read 0 and `irq_valid` is low. Select codes are: 0 status, 1 control, 2 message data, 3 address low word, 4 address high word.
- R2: A completion pulse while the flag is clear, the mask is clear and the output is idle sets the flag. It also raises `irq_valid` in the next cycle, carrying address {high word, low word} and the data word, and the pending bit stays clear.
- R3: A completion pulse while the flag is already set changes nothing and sends no message.
- R4: A completion pulse while the flag is clear and the mask is set sets the flag and the pending bit, and sends no message. The pending bit is never set while the flag is clear.
- R5: A control write with bit 31 = 0 clears the mask. If the pending bit was set, it also clears the pending bit and sends one message; if it was clear, no message is sent.
- R6: Only bit 31 of the control word is writable by software. Writing bit 30 neither sets nor clears the pending bit, and all other control bits read 0.
- R7: Writing a status word with bit 0 = 1 clears the flag and the pending bit. Writing bit 0 = 0 leaves the flag unchanged.
- R8: When a completion pulse and a status write with bit 0 = 1 occur in the same cycle, the flag ends clear, the pending bit ends clear and no message is sent.
- R9: The data, address-low and address-high words read back what was last written to them.
- R10: While `irq_valid` is high and `irq_ready` is low, `irq_valid`, `irq_addr` and `irq_data` hold. Each message is delivered exactly once.
- R11: An unmasked event that arises while the output is still holding an unaccepted message is left pending (control reads 0x4000_0000). It is launched, with the data stored at launch time, in the cycle the held message is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpl_req | input | 1 | One-cycle completion notice from the queue engine |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| irq_valid | output | 1 | Interrupt message valid |
| irq_ready | input | 1 | Interrupt message accepted |
| irq_addr | output | 64 | Interrupt message address |
| irq_data | output | 32 | Interrupt message data |

## Verification
Completion pulses are applied with the flag clear and unmasked, with the flag already set, while masked, and in the same cycle as a software flag clear. These four cases separate the edge-triggered launch, the sticky-flag suppression, the pending path and the clear-wins priority. Unmask writes are issued with the pending bit set and with it clear, which tells a replayed event from a spurious one. Control writes that touch bit 30 show that software cannot forge or drop a pending event. A run with the output stalled shows both that a held message stays stable and that a second event waits and then leaves back-to-back with the data current at launch.

// File: rtl/inv_evt_pkg.sv
// Package: shared register select codes and bit positions for the
// invalidation completion event controller.
package inv_evt_pkg;
    localparam int SEL_W    = 3;
    localparam int DONE_BIT = 0;
    localparam int N_STORE  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_CTRL    = 3'd1,
        SEL_DATA    = 3'd2,
        SEL_ADDR_LO = 3'd3,
        SEL_ADDR_HI = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/inv_evt_store.sv
// Module: plain read/write storage for message data and address words.
// Assumes the storage selects are consecutive, starting at SEL_DATA.
module inv_evt_store
    import inv_evt_pkg::*;
#(
    parameter int W = 32,
    parameter int N = N_STORE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [N*W-1:0]   store_flat
);
    for (genvar g = 0; g < N; g++) begin : g_word
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(int'(SEL_DATA) + g);
        logic [W-1:0] word_q;

        // Capture a software write addressed to this word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && (wr_sel == MY_SEL))
                word_q <= wr_data;
        end

        assign store_flat[g*W +: W] = word_q;
    end
endmodule

// File: rtl/inv_evt_status.sv
// Module: completion flag, mask and pending state plus the launch decision.
// Assumes a single write port, so a status write and a control write never
// fall in the same cycle. A software flag clear beats a coincident completion.
module inv_evt_status
    import inv_evt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpl_req,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             out_free,
    output logic             iwc,
    output logic             im,
    output logic             ip,
    output logic             launch
);
    localparam int MASK_BIT = W - 1;

    logic iwc_q, im_q, ip_q;
    logic sts_wr, ctl_wr, iwc_clr, new_cpl, im_nx, pend, iwc_nx, ip_nx;

    // Next-state and launch decision for the event bits.
    always_comb begin
        sts_wr  = wr_en && (wr_sel == SEL_STATUS);
        ctl_wr  = wr_en && (wr_sel == SEL_CTRL);
        iwc_clr = sts_wr && wr_data[DONE_BIT];
        new_cpl = cpl_req && !iwc_q && !iwc_clr;
        im_nx   = ctl_wr ? wr_data[MASK_BIT] : im_q;
        pend    = (ip_q || new_cpl) && !iwc_clr;
        launch  = pend && !im_nx && out_free;
        ip_nx   = pend && !launch;
        iwc_nx  = iwc_clr ? 1'b0 : (iwc_q || new_cpl);
    end

    // Event state registers; mask comes up set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iwc_q <= 1'b0;
            im_q  <= 1'b1;
            ip_q  <= 1'b0;
        end else begin
            iwc_q <= iwc_nx;
            im_q  <= im_nx;
            ip_q  <= ip_nx;
        end
    end

    assign iwc = iwc_q;
    assign im  = im_q;
    assign ip  = ip_q;
endmodule

// File: rtl/inv_evt_msg.sv
// Module: output holding register for the interrupt message.
// Assumes launch is only asserted when out_free is high.
module inv_evt_msg #(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    input  logic          irq_ready,
    output logic          irq_valid,
    output logic [AW-1:0] irq_addr,
    output logic [DW-1:0] irq_data,
    output logic          out_free
);
    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Output can take a new message when empty or being drained now.
    assign out_free = !valid_q || irq_ready;

    // Load on launch, drop valid on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (launch) begin
            valid_q <= 1'b1;
            addr_q  <= src_addr;
            data_q  <= src_data;
        end else if (irq_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign irq_valid = valid_q;
    assign irq_addr  = addr_q;
    assign irq_data  = data_q;
endmodule

// File: rtl/inv_cpl_evt_ctrl.sv
// Module: top of the invalidation completion event controller.
// Ties together event state, message storage, output holding register and
// a combinational read mux. Message address is {high word, low word}.
module inv_cpl_evt_ctrl
    import inv_evt_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpl_req,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [2:0]         rd_sel,
    output logic [REG_W-1:0]   rd_data,
    output logic               irq_valid,
    input  logic               irq_ready,
    output logic [2*REG_W-1:0] irq_addr,
    output logic [REG_W-1:0]   irq_data
);
    localparam int AW = 2 * REG_W;

    logic [N_STORE*REG_W-1:0] store_flat;
    logic [REG_W-1:0]         msg_data, addr_lo, addr_hi;
    logic iwc_s, im_s, ip_s, launch_s, out_free_s;

    assign msg_data = store_flat[0*REG_W +: REG_W];
    assign addr_lo  = store_flat[1*REG_W +: REG_W];
    assign addr_hi  = store_flat[2*REG_W +: REG_W];

    inv_evt_store #(.W(REG_W), .N(N_STORE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .store_flat(store_flat)
    );

    inv_evt_status #(.W(REG_W)) u_status (
        .clk(clk), .rst_n(rst_n), .cpl_req(cpl_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .out_free(out_free_s),
        .iwc(iwc_s), .im(im_s), .ip(ip_s), .launch(launch_s)
    );

    inv_evt_msg #(.AW(AW), .DW(REG_W)) u_msg (
        .clk(clk), .rst_n(rst_n), .launch(launch_s),
        .src_addr({addr_hi, addr_lo}), .src_data(msg_data),
        .irq_ready(irq_ready), .irq_valid(irq_valid),
        .irq_addr(irq_addr), .irq_data(irq_data), .out_free(out_free_s)
    );

    // Software read mux.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_STATUS:  rd_data[DONE_BIT] = iwc_s;
            SEL_CTRL: begin
                rd_data[REG_W-1] = im_s;
                rd_data[REG_W-2] = ip_s;
            end
            SEL_DATA:    rd_data = msg_data;
            SEL_ADDR_LO: rd_data = addr_lo;
            SEL_ADDR_HI: rd_data = addr_hi;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/inv_cpl_evt_chk.sv
// Module: assertion checker for inv_cpl_evt_ctrl, attached by bind below.
module inv_cpl_evt_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpl_req,
    input logic           wr_en,
    input logic [2:0]     wr_sel,
    input logic [W-1:0]   wr_data,
    input logic           irq_valid,
    input logic           irq_ready,
    input logic [2*W-1:0] irq_addr,
    input logic [W-1:0]   irq_data,
    input logic           iwc,
    input logic           im,
    input logic           ip
);
    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && !irq_ready |=> irq_valid && $stable(irq_addr) && $stable(irq_data));

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> !im);

    // R4
    pend_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip |-> iwc);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_sel == 3'd0) && wr_data[0] |=> !iwc && !ip);

    // R11
    pend_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip && !im |-> irq_valid);

    // R2
    cpl_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_req && !iwc && !im && !irq_valid && !wr_en |=> irq_valid && iwc && !ip);

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_req && wr_en && (wr_sel == 3'd0) && wr_data[0] |=> !iwc && !$rose(irq_valid));
endmodule

bind inv_cpl_evt_ctrl inv_cpl_evt_chk #(.W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpl_req(cpl_req), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_addr(irq_addr), .irq_data(irq_data),
    .iwc(iwc_s), .im(im_s), .ip(ip_s)
);

// File: tb/inv_cpl_evt_ctrl_tb.sv
// Bench: scoreboard of expected interrupt messages plus register read checks.
module inv_cpl_evt_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpl_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic        irq_ready = 1'b1;
    logic [63:0] irq_addr;
    logic [31:0] irq_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] exp_a[$];
    logic [31:0] exp_d[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    inv_cpl_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpl_req(cpl_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_ready(irq_ready),
        .irq_addr(irq_addr), .irq_data(irq_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input string tag, input logic [63:0] a, input logic [31:0] d);
        exp_a.push_back(a);
        exp_d.push_back(d);
        exp_tag.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cpl();
        @(negedge clk);
        cpl_req = 1'b1;
        @(negedge clk);
        cpl_req = 1'b0;
    endtask

    task automatic cpl_and_clear();
        @(negedge clk);
        cpl_req = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h1;
        @(negedge clk);
        cpl_req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] s, input logic [31:0] exp);
        rd_sel = s;
        #1;
        chk(tag, {32'h0, rd_data}, {32'h0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare each accepted message.
    always @(negedge clk) begin
        if (rst_n && irq_valid && irq_ready) begin
            if (exp_a.size() == 0) begin
                chk("R3/R4/R8 unexpected message", irq_addr, 64'hx);
            end else begin
                string t;
                t = exp_tag.pop_front();
                chk({t, " msg addr"}, irq_addr, exp_a.pop_front());
                chk({t, " msg data"}, {32'h0, irq_data}, {32'h0, exp_d.pop_front()});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [63:0] ADDR = 64'h0000_0001_FEE0_0000;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd_chk("R1 status", 3'd0, 32'h0);
        rd_chk("R1 control", 3'd1, 32'h8000_0000);
        rd_chk("R1 data", 3'd2, 32'h0);
        rd_chk("R1 addr hi", 3'd4, 32'h0);
        chk("R1 valid", {63'h0, irq_valid}, 64'h0);

        // R9 storage
        wr(3'd2, 32'hA5A5_0001);
        wr(3'd3, 32'hFEE0_0000);
        wr(3'd4, 32'h0000_0001);
        rd_chk("R9 data", 3'd2, 32'hA5A5_0001);
        rd_chk("R9 addr lo", 3'd3, 32'hFEE0_0000);
        rd_chk("R9 addr hi", 3'd4, 32'h0000_0001);

        // R5 unmask with nothing pending: no message
        wr(3'd1, 32'h0);
        idle(3);
        rd_chk("R5 control after unmask", 3'd1, 32'h0);

        // R2 completion unmasked
        push("R2", ADDR, 32'hA5A5_0001);
        cpl();
        idle(3);
        rd_chk("R2 status", 3'd0, 32'h1);
        rd_chk("R2 control", 3'd1, 32'h0);

        // R3 completion with flag already set
        cpl();
        idle(3);
        rd_chk("R3 status", 3'd0, 32'h1);

        // R7 write 0 has no effect, write 1 clears
        wr(3'd0, 32'h0);
        rd_chk("R7 write zero", 3'd0, 32'h1);
        wr(3'd0, 32'h1);
        rd_chk("R7 write one", 3'd0, 32'h0);

        // R6 software cannot set pending
        wr(3'd1, 32'hC000_0000);
        rd_chk("R6 pending not forged", 3'd1, 32'h8000_0000);

        // R4 masked completion
        cpl();
        idle(3);
        rd_chk("R4 status", 3'd0, 32'h1);
        rd_chk("R4 control", 3'd1, 32'hC000_0000);

        // R6 software cannot clear pending, other bits read 0
        wr(3'd1, 32'hBFFF_FFFF);
        rd_chk("R6 pending kept", 3'd1, 32'hC000_0000);

        // R5 unmask with pending: message with new data
        wr(3'd2, 32'h1234_5678);
        push("R5", ADDR, 32'h1234_5678);
        wr(3'd1, 32'h0);
        idle(3);
        rd_chk("R5 control after replay", 3'd1, 32'h0);

        // R7 clear drops pending
        wr(3'd1, 32'h8000_0000);
        wr(3'd0, 32'h1);
        cpl();
        rd_chk("R7 pending set", 3'd1, 32'hC000_0000);
        wr(3'd0, 32'h1);
        rd_chk("R7 status cleared", 3'd0, 32'h0);
        rd_chk("R7 pending cleared", 3'd1, 32'h8000_0000);

        // R8 same-cycle completion and clear, unmasked
        wr(3'd1, 32'h0);
        cpl_and_clear();
        idle(3);
        rd_chk("R8 status", 3'd0, 32'h0);
        rd_chk("R8 control", 3'd1, 32'h0);

        // R10 backpressure hold
        @(negedge clk);
        irq_ready = 1'b0;
        push("R10", ADDR, 32'h1234_5678);
        cpl();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 valid held", {63'h0, irq_valid}, 64'h1);
            chk("R10 addr held", irq_addr, ADDR);
            chk("R10 data held", {32'h0, irq_data}, 64'h1234_5678);
        end

        // R11 event while output busy waits, then leaves back-to-back
        wr(3'd2, 32'hBEEF_0002);
        wr(3'd0, 32'h1);
        push("R11", ADDR, 32'hBEEF_0002);
        cpl();
        rd_chk("R11 pending while busy", 3'd1, 32'h4000_0000);
        rd_chk("R11 status", 3'd0, 32'h1);
        @(negedge clk);
        irq_ready = 1'b1;
        idle(4);
        rd_chk("R11 control drained", 3'd1, 32'h0);
        chk("R10 all delivered", 64'(exp_a.size()), 64'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule